// File: doc/BRIEF.md
# Delayed register write scheduler

This block holds register writes that must land a fixed number of instruction cycles after they are requested, the way load results and coprocessor moves arrive late in a pipeline with exposed delay slots. A producer posts a request with a destination index, a value, a delay and an optional single-bit target. The issue logic pulses `tick` once at the start of every instruction, before that instruction's own effects. Each held entry counts down its own delay on those ticks. When an entry runs out, its write is presented on the commit port for exactly one cycle, and the register file applies it under the bit-enable mask.

The store is a ring of slots filled in order by an insert pointer that wraps around. A request that finds the slot under the insert pointer still busy is not stalled. It is refused and reported on `ovf_err`. Several entries can expire on the same tick. They then leave one per cycle, oldest first. `flush` throws away everything pending. A write to a register wider than the commit path is posted by the caller as two separate requests.

Top module: `delay_write_sched`

## Requirements
- R1: After reset `wr_vld` and `ovf_err` are 0 and `pend_cnt` is 0.
- R2: A request accepted with `sched_dly` = d is committed after exactly d+1 ticks. `wr_vld` rises in the cycle after the edge that samples the last of those ticks. Cycles without `tick` do not count.
- R3: A request made while the slot under the insert pointer is occupied raises `ovf_err` for the following cycle only. The request is dropped, `pend_cnt` does not grow, and the request is never committed.
- R4: When `sched_bit_en` = 1, the commit has a one-hot `wr_mask` with its 1 at bit position `sched_bit`. `wr_data` carries bit 0 of `sched_data` at that position and zeros elsewhere.
- R5: When `sched_bit_en` = 0, the commit has `wr_mask` all ones and `wr_data` equal to `sched_data`, with the requested `wr_idx`.
- R6: Entries that are due at the same time are committed one per cycle in the order they were accepted. A younger entry that expires first is committed before an older entry that has not yet expired.
- R7: A request accepted on the same edge as a tick is not counted down by that tick.
- R8: `flush` discards all pending entries, including a request in the same cycle. No commit appears in the cycle after the flush edge or later from discarded entries, and `pend_cnt` reads 0.
- R9: `pend_cnt` equals the number of accepted entries not yet committed. It rises by one per accepted request and falls by one per commit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sched_vld | input | 1 | Post a delayed write this cycle |
| sched_idx | input | 7 | Destination register index |
| sched_data | input | 32 | Value to write (bit 0 only in bit mode) |
| sched_dly | input | 3 | Delay in ticks, entry commits after sched_dly+1 ticks |
| sched_bit_en | input | 1 | 1: update a single bit, 0: whole register |
| sched_bit | input | 5 | Bit position used when sched_bit_en is 1 |
| tick | input | 1 | Instruction issue strobe |
| flush | input | 1 | Discard every pending write |
| wr_vld | output | 1 | Commit strobe to the register file |
| wr_idx | output | 7 | Commit destination index |
| wr_data | output | 32 | Commit value |
| wr_mask | output | 32 | Bits of the destination to update |
| ovf_err | output | 1 | Request refused because its slot was busy |
| pend_cnt | output | 4 | Number of pending entries |

## Verification
The hardest state to reach is a full ring in which every entry expires on one tick. In that state a further request must be refused while eight commits drain in acceptance order. The stimulus posts eight requests with the longest delay and no ticks, then posts a ninth to provoke the refusal. It then gives the ticks that expire all eight at once, so the drain order and the absence of the refused value can both be read at the commit port. A second sequence flushes in the middle of such a drain to show that the remaining commits vanish.

// File: rtl/dws_pkg.sv
`timescale 1ns/1ps
package dws_pkg;
    localparam int SLOTS  = 8;
    localparam int PTR_W  = $clog2(SLOTS);
    localparam int IDX_W  = 7;
    localparam int DATA_W = 32;
    localparam int BIT_W  = $clog2(DATA_W);
    localparam int DLY_W  = 3;
    localparam int CNT_W  = DLY_W + 1;
    localparam int OCC_W  = $clog2(SLOTS + 1);

    typedef struct packed {
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] data;
        logic              bit_en;
        logic [BIT_W-1:0]  bit_pos;
    } wr_req_t;

    typedef struct packed {
        logic             vld;
        logic [CNT_W-1:0] left;
        wr_req_t          req;
    } slot_t;

    function automatic logic [DATA_W-1:0] lane_mask(input wr_req_t r);
        return r.bit_en ? (DATA_W'(1) << r.bit_pos) : {DATA_W{1'b1}};
    endfunction

    function automatic logic [DATA_W-1:0] lane_data(input wr_req_t r);
        if (r.bit_en)
            return r.data[0] ? lane_mask(r) : '0;
        return r.data;
    endfunction
endpackage

// File: rtl/dws_slot.sv
`timescale 1ns/1ps
module dws_slot
    import dws_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             load,
    input  wr_req_t          load_req,
    input  logic [DLY_W-1:0] load_dly,
    input  logic             tick,
    input  logic             drop,
    output slot_t            st,
    output logic             due
);
    always_ff @(posedge clk) begin
        if (rst || flush) begin
            st <= '0;
        end else if (drop) begin
            st.vld <= 1'b0;
        end else if (load) begin
            st.vld  <= 1'b1;
            st.left <= CNT_W'(load_dly) + CNT_W'(1);
            st.req  <= load_req;
        end else if (tick && st.vld && st.left != '0) begin
            st.left <= st.left - CNT_W'(1);
        end
    end

    assign due = st.vld && (st.left == '0);
endmodule

// File: rtl/dws_pick.sv
`timescale 1ns/1ps
module dws_pick
    import dws_pkg::*;
(
    input  logic [SLOTS-1:0] due,
    input  logic [PTR_W-1:0] start,
    output logic             found,
    output logic [PTR_W-1:0] sel
);
    always_comb begin
        logic [PTR_W-1:0] pos;
        found = 1'b0;
        sel   = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            pos = start + PTR_W'(i);
            if (due[pos]) begin
                found = 1'b1;
                sel   = pos;
            end
        end
    end
endmodule

// File: rtl/delay_write_sched.sv
`timescale 1ns/1ps
module delay_write_sched
    import dws_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sched_vld,
    input  logic [IDX_W-1:0]  sched_idx,
    input  logic [DATA_W-1:0] sched_data,
    input  logic [DLY_W-1:0]  sched_dly,
    input  logic              sched_bit_en,
    input  logic [BIT_W-1:0]  sched_bit,
    input  logic              tick,
    input  logic              flush,
    output logic              wr_vld,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] wr_mask,
    output logic              ovf_err,
    output logic [OCC_W-1:0]  pend_cnt
);
    slot_t            slots [SLOTS];
    logic [SLOTS-1:0] due_vec;
    logic [PTR_W-1:0] ins_ptr;
    logic             accept;
    logic             found;
    logic [PTR_W-1:0] sel;
    wr_req_t          new_req;
    wr_req_t          out_req;

    assign new_req = '{idx: sched_idx, data: sched_data,
                       bit_en: sched_bit_en, bit_pos: sched_bit};
    assign accept  = sched_vld && !slots[ins_ptr].vld && !flush;
    assign out_req = slots[sel].req;

    for (genvar k = 0; k < SLOTS; k++) begin : g_slot
        dws_slot u_slot (
            .clk      (clk),
            .rst      (rst),
            .flush    (flush),
            .load     (accept && (ins_ptr == PTR_W'(k))),
            .load_req (new_req),
            .load_dly (sched_dly),
            .tick     (tick),
            .drop     (found && (sel == PTR_W'(k))),
            .st       (slots[k]),
            .due      (due_vec[k])
        );
    end

    // Slots were filled in ring order from the insert pointer, so the
    // first due slot found scanning from it is the oldest due entry.
    dws_pick u_pick (
        .due   (due_vec),
        .start (ins_ptr),
        .found (found),
        .sel   (sel)
    );

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            ins_ptr  <= '0;
            pend_cnt <= '0;
            wr_vld   <= 1'b0;
            ovf_err  <= 1'b0;
            wr_idx   <= '0;
            wr_data  <= '0;
            wr_mask  <= '0;
        end else begin
            ovf_err  <= sched_vld && !accept;
            if (accept)
                ins_ptr <= ins_ptr + PTR_W'(1);
            pend_cnt <= pend_cnt + OCC_W'(accept) - OCC_W'(found);
            wr_vld   <= found;
            if (found) begin
                wr_idx  <= out_req.idx;
                wr_data <= lane_data(out_req);
                wr_mask <= lane_mask(out_req);
            end
        end
    end
endmodule

// File: rtl/dws_chk.sv
`timescale 1ns/1ps
module dws_chk
    import dws_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              sched_vld,
    input logic              flush,
    input logic              wr_vld,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] wr_mask,
    input logic              ovf_err,
    input logic [OCC_W-1:0]  pend_cnt
);
    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!wr_vld && !ovf_err && pend_cnt == '0));

    assert_refused_keeps_count_R3: assert property (@(posedge clk) disable iff (rst)
        (ovf_err && !$past(rst)) |->
            ($past(sched_vld) && pend_cnt == $past(pend_cnt) - OCC_W'(wr_vld)));

    assert_lane_shape_R4: assert property (@(posedge clk) disable iff (rst)
        wr_vld |-> (((wr_data & ~wr_mask) == '0) &&
                    (($countones(wr_mask) == 1) || (&wr_mask))));

    assert_flush_empties_R8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(flush)) |-> (pend_cnt == '0 && !wr_vld));

    assert_count_tracks_R9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(flush)) |->
            (pend_cnt == $past(pend_cnt) + OCC_W'($past(sched_vld) && !ovf_err)
                         - OCC_W'(wr_vld)));

    assert_count_bound_R9: assert property (@(posedge clk) disable iff (rst)
        pend_cnt <= OCC_W'(SLOTS));
endmodule

bind delay_write_sched dws_chk i_dws_chk (
    .clk       (clk),
    .rst       (rst),
    .sched_vld (sched_vld),
    .flush     (flush),
    .wr_vld    (wr_vld),
    .wr_data   (wr_data),
    .wr_mask   (wr_mask),
    .ovf_err   (ovf_err),
    .pend_cnt  (pend_cnt)
);

// File: tb/test_delay_write_sched.sv
`timescale 1ns/1ps
module test_delay_write_sched;
    import dws_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              sched_vld = 1'b0;
    logic [IDX_W-1:0]  sched_idx = '0;
    logic [DATA_W-1:0] sched_data = '0;
    logic [DLY_W-1:0]  sched_dly = '0;
    logic              sched_bit_en = 1'b0;
    logic [BIT_W-1:0]  sched_bit = '0;
    logic              tick = 1'b0;
    logic              flush = 1'b0;
    logic              wr_vld;
    logic [IDX_W-1:0]  wr_idx;
    logic [DATA_W-1:0] wr_data;
    logic [DATA_W-1:0] wr_mask;
    logic              ovf_err;
    logic [OCC_W-1:0]  pend_cnt;

    always #4 clk = ~clk;

    delay_write_sched i_delay_write_sched (
        .clk(clk), .rst(rst), .sched_vld(sched_vld), .sched_idx(sched_idx),
        .sched_data(sched_data), .sched_dly(sched_dly), .sched_bit_en(sched_bit_en),
        .sched_bit(sched_bit), .tick(tick), .flush(flush), .wr_vld(wr_vld),
        .wr_idx(wr_idx), .wr_data(wr_data), .wr_mask(wr_mask),
        .ovf_err(ovf_err), .pend_cnt(pend_cnt)
    );

    typedef struct {
        int                cyc;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] data;
        logic [DATA_W-1:0] mask;
        string             req;
    } exp_t;

    exp_t sb[$];
    int   checks = 0;
    int   fails  = 0;
    int   cyc    = 0;

    localparam logic [DATA_W-1:0] ALL = {DATA_W{1'b1}};

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic expect_at(input int at, input int idx,
                             input logic [DATA_W-1:0] data,
                             input logic [DATA_W-1:0] mask, input string req);
        exp_t e;
        e.cyc = at; e.idx = IDX_W'(idx); e.data = data; e.mask = mask; e.req = req;
        sb.push_back(e);
    endtask

    // Monitor: every commit must match the head of the scoreboard in cycle and content.
    always @(negedge clk) begin
        if (!rst) begin
            if (wr_vld) begin
                checks++;
                if (sb.size() == 0) begin
                    fails++;
                    $display("FAIL R3 unexpected commit idx=%0h data=%0h actual=commit expected=none",
                             wr_idx, wr_data);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    if (e.cyc != cyc || wr_idx !== e.idx || wr_data !== e.data || wr_mask !== e.mask) begin
                        fails++;
                        $display("FAIL %s commit actual=cyc%0d/%0h/%0h/%0h expected=cyc%0d/%0h/%0h/%0h",
                                 e.req, cyc, wr_idx, wr_data, wr_mask, e.cyc, e.idx, e.data, e.mask);
                    end
                end
            end else if (sb.size() != 0 && sb[0].cyc == cyc) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                fails++;
                $display("FAIL %s missing commit actual=none expected=cyc%0d/%0h", e.req, e.cyc, e.data);
            end
        end
    end

    task automatic step(input logic sv, input int idx, input logic [DATA_W-1:0] data,
                        input int dly, input logic ben, input int bpos,
                        input logic tk, input logic fl);
        sched_vld    = sv;
        sched_idx    = IDX_W'(idx);
        sched_data   = data;
        sched_dly    = DLY_W'(dly);
        sched_bit_en = ben;
        sched_bit    = BIT_W'(bpos);
        tick         = tk;
        flush        = fl;
        @(posedge clk);
        @(negedge clk);
        sched_vld = 1'b0; tick = 1'b0; flush = 1'b0; sched_bit_en = 1'b0;
    endtask

    task automatic post(input int idx, input logic [DATA_W-1:0] data, input int dly);
        step(1'b1, idx, data, dly, 1'b0, 0, 1'b0, 1'b0);
    endtask

    task automatic tk1();
        step(1'b0, 0, '0, 0, 1'b0, 0, 1'b1, 1'b0);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 0, '0, 0, 1'b0, 0, 1'b0, 1'b0);
    endtask

    initial begin
        #(200000 * 8);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: quiet after reset
        chk("R1", "wr_vld", wr_vld, 0);
        chk("R1", "ovf_err", ovf_err, 0);
        chk("R1", "pend_cnt", pend_cnt, 0);

        // R2/R5: delay 0 whole-register write, idle cycles do not count
        post(3, 32'hDEADBEEF, 0);
        chk("R9", "pend_cnt after one post", pend_cnt, 1);
        idle(2);
        expect_at(cyc + 2, 3, 32'hDEADBEEF, ALL, "R5");
        tk1();
        idle(1);
        chk("R9", "pend_cnt after commit", pend_cnt, 0);
        idle(1);

        // R2: delay 2 needs three ticks, with gaps between them
        post(10, 32'h12345678, 2);
        tk1(); idle(1); tk1(); idle(3);
        expect_at(cyc + 2, 10, 32'h12345678, ALL, "R2");
        tk1();
        idle(2);

        // R4 and R6: two single-bit writes due on one tick leave in post order
        step(1'b1, 20, 32'h00000001, 0, 1'b1, 9, 1'b0, 1'b0);
        step(1'b1, 21, 32'hFFFFFFFE, 0, 1'b1, 31, 1'b0, 1'b0);
        expect_at(cyc + 2, 20, 32'h00000200, 32'h00000200, "R4");
        expect_at(cyc + 3, 21, 32'h00000000, 32'h80000000, "R4");
        tk1();
        idle(3);

        // R7: post together with a tick is not counted down by it
        step(1'b1, 7, 32'hAAAA5555, 0, 1'b0, 0, 1'b1, 1'b0);
        idle(2);
        expect_at(cyc + 2, 7, 32'hAAAA5555, ALL, "R7");
        tk1();
        idle(2);

        // R6: younger entry that expires first goes first
        post(1, 32'h0000A001, 1);
        post(2, 32'h0000B002, 0);
        expect_at(cyc + 2, 2, 32'h0000B002, ALL, "R6");
        expect_at(cyc + 3, 1, 32'h0000A001, ALL, "R6");
        tk1(); tk1();
        idle(3);

        // R3: fill the ring, refuse a ninth, then drain all eight in order
        for (int k = 0; k < SLOTS; k++) post(40 + k, DATA_W'(32'h1111 * (k + 1)), 7);
        chk("R9", "pend_cnt full", pend_cnt, SLOTS);
        post(99, 32'hBADBAD00, 0);
        chk("R3", "ovf_err raised", ovf_err, 1);
        chk("R3", "pend_cnt unchanged", pend_cnt, SLOTS);
        idle(1);
        chk("R3", "ovf_err one cycle", ovf_err, 0);
        for (int k = 0; k < 7; k++) tk1();
        for (int k = 0; k < SLOTS; k++)
            expect_at(cyc + 2 + k, 40 + k, DATA_W'(32'h1111 * (k + 1)), ALL, "R6");
        tk1();
        idle(3);
        chk("R9", "pend_cnt mid drain", pend_cnt, SLOTS - 3);
        idle(8);

        // R8: flush in the middle of a drain and together with a post
        for (int k = 0; k < 4; k++) post(60 + k, DATA_W'(k + 5), 0);
        expect_at(cyc + 2, 60, DATA_W'(5), ALL, "R8");
        tk1();
        idle(1);
        step(1'b0, 0, '0, 0, 1'b0, 0, 1'b0, 1'b1);
        chk("R8", "pend_cnt after flush", pend_cnt, 0);
        step(1'b1, 70, 32'h77, 0, 1'b0, 0, 1'b0, 1'b1);
        chk("R8", "post with flush dropped", pend_cnt, 0);
        tk1(); tk1(); idle(4);

        chk("R2", "unmet expectations", sb.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule